// File: doc/BRIEF.md
# Configuration Capability List Walker

This engine finds where a requested capability lives inside one function's configuration space. Software or a neighbouring block raises `start` with a capability ID and a list selector. The engine then issues dword reads through a request/response read port, decodes each capability header it fetches, and follows the chain of next pointers. The walk ends on a match, on a null next pointer, or when a hop limit runs out.

Two list formats are handled. In the standard list, the engine first confirms the capability-list flag in the status half of the header dword and then fetches the head pointer. Each header there carries an 8-bit ID and an 8-bit link. The extended list always begins at byte offset 100h. Its headers hold a 16-bit ID, a 4-bit version and a 12-bit link. A hop limit for each format turns a circular or malformed chain into a reported error rather than a hung engine.

When the walk finishes, a one-cycle `done` pulse is raised. The found and error flags, the offset of the matching header and the number of headers read are held until the next walk starts.

Top module: `cap_walker`

## Requirements
- R1: After reset, `busy`, `done`, `found`, `err` and `rd_req_valid` are all 0.
- R2: In standard mode the first read is the dword at byte address 004h. If bit 20 of that dword (status bit 4, capability list present) is 0, the walk ends not found with `hop_cnt` = 0.
- R3: In standard mode the head pointer is bits 7:0 of the dword at 034h, with its two low bits forced to 0. A head of zero ends the walk not found with `hop_cnt` = 0.
- R4: A standard header is matched on bits 7:0 against `cap_id[7:0]`; `cap_id[15:8]` is ignored. Its next pointer is bits 15:8 with the two low bits forced to 0, so every read address is dword aligned.
- R5: In extended mode the first read is at byte address 100h. Each header is matched on bits 15:0 against all 16 bits of `cap_id`, and its next pointer is bits 31:20 with the two low bits forced to 0.
- R6: On a match, `found` = 1, `err` = 0, `cap_off` is the byte address of the matching header, and `hop_cnt` is the number of headers read, counting the matching one.
- R7: A non-matching header whose next pointer is zero ends the walk with `found` = 0, `err` = 0 and `cap_off` = 0.
- R8: After 48 standard or 960 extended headers have been read with no match and a non-zero next pointer, the walk ends with `err` = 1, `found` = 0 and `hop_cnt` equal to the limit.
- R9: A read request holds `rd_req_valid` and a stable `rd_req_addr` until `rd_req_ready` is seen. Only one read is outstanding at a time, and no request is raised while `busy` is 0.
- R10: `done` is high for exactly one cycle. The results stay held until the next accepted start. A `start` that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| ext_mode | input | 1 | 0 = standard list, 1 = extended list |
| cap_id | input | 16 | Capability ID to search for |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_addr | output | ADDR_W (12) | Byte address of the requested dword |
| rd_req_ready | input | 1 | Read request accepted |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| found | output | 1 | Capability located |
| err | output | 1 | Hop limit reached |
| cap_off | output | ADDR_W (12) | Byte offset of the matching header |
| hop_cnt | output | HOP_W (10) | Headers read in the last walk |

## Verification
The hardest condition to reach from the ports is the hop-limit abort. It needs a chain that never ends and never matches, and for the extended list it needs 960 round trips. The bench sets this up by writing a header whose next pointer points back to its own offset, in the configuration image that its read responder serves. It then lets the walk run with a ready signal that stalls in a fixed pattern. Overlap with a running walk is reached by pulsing `start` again a few cycles after the first start. The result of the first walk must come out unchanged.

// File: rtl/capwalk_pkg.sv
package capwalk_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_STAT, W_HEAD, W_HDR, W_CMP, W_ADV, W_DONE
  } walk_st_t;

  typedef enum logic [1:0] {
    P_IDLE, P_REQ, P_WAIT
  } port_st_t;
endpackage

// File: rtl/cap_rd_port.sv
module cap_rd_port #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  output logic              rsp_done,
  output logic [31:0]       rsp_q
);
  import capwalk_pkg::*;

  port_st_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= P_IDLE;
      req_valid <= 1'b0;
      req_addr  <= '0;
      rsp_done  <= 1'b0;
      rsp_q     <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        P_IDLE: if (go) begin
          req_valid <= 1'b1;
          req_addr  <= go_addr;
          st        <= P_REQ;
        end
        P_REQ: if (req_ready) begin
          req_valid <= 1'b0;
          st        <= P_WAIT;
        end
        P_WAIT: if (rsp_valid) begin
          rsp_q    <= rsp_data;
          rsp_done <= 1'b1;
          st       <= P_IDLE;
        end
        default: st <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cap_hdr_decode.sv
module cap_hdr_decode #(
  parameter int ADDR_W = 12
) (
  input  logic              ext,
  input  logic [31:0]       data,
  output logic [15:0]       id,
  output logic [ADDR_W-1:0] nxt
);
  logic unused_fields;
  assign unused_fields = ^{data[21:16], data[9:8]};

  always_comb begin
    if (ext) begin
      id  = data[15:0];
      nxt = ADDR_W'({data[31:22], 2'b00});
    end else begin
      id  = {8'h00, data[7:0]};
      nxt = ADDR_W'({data[15:10], 2'b00});
    end
  end
endmodule

// File: rtl/cap_walk_ctl.sv
module cap_walk_ctl #(
  parameter int ADDR_W   = 12,
  parameter int MAX_STD  = 48,
  parameter int MAX_EXT  = 960,
  parameter int EXT_BASE = 'h100,
  parameter int STAT_OFF = 'h004,
  parameter int CPTR_OFF = 'h034,
  parameter int HOP_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ext,
  input  logic [15:0]       cap_id,
  output logic              go,
  output logic [ADDR_W-1:0] go_addr,
  input  logic              rsp_done,
  input  logic              stat_flag,
  input  logic [5:0]        head_ptr,
  input  logic [15:0]       hdr_id,
  input  logic [ADDR_W-1:0] hdr_nxt,
  output logic              mode_q,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic              err,
  output logic [ADDR_W-1:0] cap_off,
  output logic [HOP_W-1:0]  hops
);
  import capwalk_pkg::*;

  walk_st_t          st;
  logic              pend;
  logic [ADDR_W-1:0] ptr;
  logic [15:0]       id_q;
  logic [HOP_W-1:0]  limit;
  logic [ADDR_W-1:0] head_addr;

  assign limit     = mode_q ? HOP_W'(MAX_EXT) : HOP_W'(MAX_STD);
  assign head_addr = ADDR_W'({head_ptr, 2'b00});
  assign go        = !pend && (st == W_STAT || st == W_HEAD || st == W_HDR);

  always_comb begin
    case (st)
      W_STAT:  go_addr = ADDR_W'(STAT_OFF);
      W_HEAD:  go_addr = ADDR_W'(CPTR_OFF);
      default: go_addr = ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= W_IDLE;
      pend    <= 1'b0;
      ptr     <= '0;
      id_q    <= '0;
      mode_q  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      found   <= 1'b0;
      err     <= 1'b0;
      cap_off <= '0;
      hops    <= '0;
    end else begin
      done <= 1'b0;
      if (go)            pend <= 1'b1;
      else if (rsp_done) pend <= 1'b0;
      case (st)
        W_IDLE: if (start) begin
          mode_q  <= ext;
          id_q    <= ext ? cap_id : {8'h00, cap_id[7:0]};
          hops    <= '0;
          found   <= 1'b0;
          err     <= 1'b0;
          cap_off <= '0;
          busy    <= 1'b1;
          ptr     <= ADDR_W'(EXT_BASE);
          st      <= ext ? W_HDR : W_STAT;
        end
        W_STAT: if (rsp_done) begin
          if (stat_flag) st <= W_HEAD;
          else begin
            st <= W_DONE; done <= 1'b1; busy <= 1'b0;
          end
        end
        W_HEAD: if (rsp_done) begin
          if (head_addr == '0) begin
            st <= W_DONE; done <= 1'b1; busy <= 1'b0;
          end else begin
            ptr <= head_addr;
            st  <= W_HDR;
          end
        end
        W_HDR: if (rsp_done) begin
          hops <= hops + 1'b1;
          st   <= W_CMP;
        end
        W_CMP: begin
          if (hdr_id == id_q) begin
            found   <= 1'b1;
            cap_off <= ptr;
            st <= W_DONE; done <= 1'b1; busy <= 1'b0;
          end else if (hdr_nxt == '0) begin
            st <= W_DONE; done <= 1'b1; busy <= 1'b0;
          end else if (hops == limit) begin
            err <= 1'b1;
            st <= W_DONE; done <= 1'b1; busy <= 1'b0;
          end else begin
            st <= W_ADV;
          end
        end
        W_ADV: begin
          ptr <= hdr_nxt;
          st  <= W_HDR;
        end
        W_DONE:  st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cap_walker.sv
module cap_walker #(
  parameter int ADDR_W   = 12,
  parameter int MAX_STD  = 48,
  parameter int MAX_EXT  = 960,
  parameter int EXT_BASE = 'h100,
  parameter int STAT_OFF = 'h004,
  parameter int CPTR_OFF = 'h034,
  localparam int HOP_W   = $clog2(MAX_EXT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ext_mode,
  input  logic [15:0]       cap_id,
  output logic              rd_req_valid,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic              err,
  output logic [ADDR_W-1:0] cap_off,
  output logic [HOP_W-1:0]  hop_cnt
);
  localparam int STAT_BIT = 16 + 4;

  logic              go;
  logic [ADDR_W-1:0] go_addr;
  logic              rsp_done;
  logic [31:0]       rsp_q;
  logic              mode_q;
  logic [15:0]       hdr_id;
  logic [ADDR_W-1:0] hdr_nxt;

  cap_rd_port #(.ADDR_W(ADDR_W)) port_i (
    .clk(clk), .rst(rst), .go(go), .go_addr(go_addr),
    .req_valid(rd_req_valid), .req_addr(rd_req_addr), .req_ready(rd_req_ready),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data),
    .rsp_done(rsp_done), .rsp_q(rsp_q)
  );

  cap_hdr_decode #(.ADDR_W(ADDR_W)) dec_i (
    .ext(mode_q), .data(rsp_q), .id(hdr_id), .nxt(hdr_nxt)
  );

  cap_walk_ctl #(
    .ADDR_W(ADDR_W), .MAX_STD(MAX_STD), .MAX_EXT(MAX_EXT),
    .EXT_BASE(EXT_BASE), .STAT_OFF(STAT_OFF), .CPTR_OFF(CPTR_OFF), .HOP_W(HOP_W)
  ) ctl_i (
    .clk(clk), .rst(rst), .start(start), .ext(ext_mode), .cap_id(cap_id),
    .go(go), .go_addr(go_addr), .rsp_done(rsp_done),
    .stat_flag(rsp_q[STAT_BIT]), .head_ptr(rsp_q[7:2]),
    .hdr_id(hdr_id), .hdr_nxt(hdr_nxt), .mode_q(mode_q),
    .busy(busy), .done(done), .found(found), .err(err),
    .cap_off(cap_off), .hops(hop_cnt)
  );
endmodule

// File: rtl/cap_walker_chk.sv
module cap_walker_chk #(
  parameter int ADDR_W  = 12,
  parameter int HOP_W   = 10,
  parameter int MAX_EXT = 960
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req_valid,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_req_ready,
  input logic              busy,
  input logic              done,
  input logic              found,
  input logic              err,
  input logic [HOP_W-1:0]  hop_cnt
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R9
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_req_valid);

  // R4
  addr_align_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> rd_req_addr[1:0] == 2'b00);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  found_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(found && err));

  // R8
  hop_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> hop_cnt <= HOP_W'(MAX_EXT));
endmodule

bind cap_walker cap_walker_chk #(.ADDR_W(ADDR_W), .HOP_W(HOP_W), .MAX_EXT(MAX_EXT)) chk_i (
  .clk(clk), .rst(rst), .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
  .rd_req_ready(rd_req_ready), .busy(busy), .done(done), .found(found),
  .err(err), .hop_cnt(hop_cnt)
);

// File: tb/cap_walker_tb_top.sv
module cap_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ext_mode = 1'b0;
  logic [15:0] cap_id = '0;
  logic        rd_req_valid;
  logic [11:0] rd_req_addr;
  logic        rd_req_ready;
  logic        rd_rsp_valid;
  logic [31:0] rd_rsp_data;
  logic        busy, done, found, err;
  logic [11:0] cap_off;
  logic [9:0]  hop_cnt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cap_walker dut_i (
    .clk(clk), .rst(rst), .start(start), .ext_mode(ext_mode), .cap_id(cap_id),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .busy(busy), .done(done), .found(found), .err(err),
    .cap_off(cap_off), .hop_cnt(hop_cnt)
  );

  // configuration image served by the responder
  logic [31:0] cfg [0:1023];
  logic [2:0]  rdy_cnt;
  logic [1:0]  lat;
  logic [11:0] lat_addr;
  logic        first_pend;
  logic [11:0] first_addr;

  always @(posedge clk) begin
    if (rst) begin
      rdy_cnt      <= '0;
      rd_req_ready <= 1'b0;
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
      lat          <= '0;
      lat_addr     <= '0;
      first_pend   <= 1'b0;
      first_addr   <= '0;
    end else begin
      rdy_cnt      <= rdy_cnt + 1'b1;
      rd_req_ready <= rdy_cnt[0] | rdy_cnt[2];
      rd_rsp_valid <= 1'b0;
      if (lat == 2'd1) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= cfg[lat_addr[11:2]];
      end
      if (lat != 2'd0) lat <= lat - 1'b1;
      if (start && !busy) first_pend <= 1'b1;
      if (rd_req_valid && rd_req_ready) begin
        lat      <= 2'd2;
        lat_addr <= rd_req_addr;
        if (first_pend) begin
          first_addr <= rd_req_addr;
          first_pend <= 1'b0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load_image();
    for (int i = 0; i < 1024; i++) cfg[i] = 32'h0;
    cfg[1]   = 32'h0010_0000;  // status bit 4 set
    cfg[13]  = 32'hABCD_EF41;  // head 41h -> 40h
    cfg[16]  = 32'h1234_5001;  // 040h: id 01, next 50h
    cfg[20]  = 32'h0000_6205;  // 050h: id 05, next 62h -> 60h
    cfg[24]  = 32'h0000_0010;  // 060h: id 10, end
    cfg[64]  = 32'h1401_0001;  // 100h: id 0001, next 140h
    cfg[80]  = 32'h2001_000B;  // 140h: id 000B, next 200h
    cfg[128] = 32'h0002_0019;  // 200h: id 0019, end
  endtask

  task automatic walk(input logic e, input logic [15:0] id);
    @(negedge clk);
    ext_mode = e; cap_id = id; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    do @(negedge clk); while (!done);
  endtask

  localparam int NV = 9;
  // {ext, id, found, err, off, hops}
  localparam logic [40:0] VECS [NV] = '{
    {1'b0, 16'h0001, 1'b1, 1'b0, 12'h040, 10'd1},
    {1'b0, 16'h0005, 1'b1, 1'b0, 12'h050, 10'd2},
    {1'b0, 16'h0010, 1'b1, 1'b0, 12'h060, 10'd3},
    {1'b0, 16'h0011, 1'b0, 1'b0, 12'h000, 10'd3},
    {1'b1, 16'h0001, 1'b1, 1'b0, 12'h100, 10'd1},
    {1'b1, 16'h000B, 1'b1, 1'b0, 12'h140, 10'd2},
    {1'b1, 16'h0019, 1'b1, 1'b0, 12'h200, 10'd3},
    {1'b1, 16'h0501, 1'b0, 1'b0, 12'h000, 10'd3},
    {1'b0, 16'hAB01, 1'b1, 1'b0, 12'h040, 10'd1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    load_image();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy",  busy, 0);
    chk("R1 done",  done, 0);
    chk("R1 found", found, 0);
    chk("R1 err",   err, 0);
    chk("R1 req",   rd_req_valid, 0);

    // R4 R5 R6 R7: table walk over both lists
    for (int v = 0; v < NV; v++) begin
      walk(VECS[v][40], VECS[v][39:24]);
      chk($sformatf("R6 found v%0d", v), found, VECS[v][23]);
      chk($sformatf("R7 err v%0d", v), err, VECS[v][22]);
      chk($sformatf("R6 off v%0d", v), cap_off, VECS[v][21:10]);
      chk($sformatf("R6 hops v%0d", v), hop_cnt, VECS[v][9:0]);
      chk($sformatf("R2 R5 first addr v%0d", v), first_addr,
          VECS[v][40] ? 32'h100 : 32'h004);
    end

    // R10: done lasts one cycle, result held
    @(negedge clk);
    chk("R10 done low", done, 0);
    chk("R10 held found", found, 1);

    // R2: capability list flag clear
    cfg[1] = 32'h0000_FFFF;
    walk(1'b0, 16'h0001);
    chk("R2 found", found, 0);
    chk("R2 hops", hop_cnt, 0);
    chk("R2 err", err, 0);

    // R3: head pointer masks to zero
    cfg[1]  = 32'h0010_0000;
    cfg[13] = 32'hFFFF_FF03;
    walk(1'b0, 16'h0001);
    chk("R3 found", found, 0);
    chk("R3 hops", hop_cnt, 0);

    // R8: standard self loop
    cfg[13] = 32'h0000_0040;
    cfg[16] = 32'h0000_4009;
    walk(1'b0, 16'h0022);
    chk("R8 std err", err, 1);
    chk("R8 std found", found, 0);
    chk("R8 std hops", hop_cnt, 48);

    // R8: extended self loop
    cfg[64] = 32'h1001_0003;
    walk(1'b1, 16'h0004);
    chk("R8 ext err", err, 1);
    chk("R8 ext hops", hop_cnt, 960);

    // R10: start while busy is ignored
    load_image();
    @(negedge clk);
    ext_mode = 1'b0; cap_id = 16'h0010; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 busy", busy, 1);
    ext_mode = 1'b1; cap_id = 16'h0001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R10 ignored found", found, 1);
    chk("R10 ignored off", cap_off, 12'h060);
    chk("R10 ignored hops", hop_cnt, 3);
    @(negedge clk);
    chk("R9 idle no req", rd_req_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule